// File: doc/BRIEF.md
# Coalescing Deferred Request Queue

This block sits in front of a memory controller and parks pre-compute requests that software has chosen to defer. Each request carries an identifier, a target address and a data word. An incoming request is stored and is not passed on. If its address is already held, it replaces the stored identifier and data in that same slot, so repeated updates to one location take up only one slot. A request leaves only when a fire command names its identifier. The departing request is then placed in a one-deep output register toward the intermediate result buffer, and stays there until the downstream side accepts it.

Requests do not leave in arrival order. A new address that arrives when every slot is occupied is dropped with no signal to anyone. Losing it costs performance but cannot make results wrong. A fire that names an identifier not held in the queue has no effect. If a fire and an enqueue reach the same slot in one cycle, the fire is taken first: the old contents go out, and the incoming request is stored as a new entry.

Top module: `coalesceQueue`

## Requirements
- R1: After reset the queue holds no entries and `outValid` is low; a fire issued before any enqueue produces no output.
- R2: An enqueued request is not forwarded: without a fire command, `outValid` does not rise.
- R3: An enqueue whose address equals a held entry's address overwrites that entry's identifier and data and uses no new slot; a later fire naming the replaced identifier produces nothing.
- R4: A fire naming a held identifier, accepted at clock edge N, makes `outValid` high after edge N. The output then carries that entry's identifier, address and data, and the entry is removed, so a repeated fire with the same identifier produces nothing.
- R5: A fire naming an identifier that is not held is ignored and leaves the queue unchanged.
- R6: While `outValid` is high and `outReady` is low, the output fields are held stable. `outValid` falls after an edge where `outReady` is high, unless a new fire is loaded in that same edge.
- R7: When all DEPTH (default 8) slots are occupied and no fire frees one, an enqueue to an address that matches no entry is discarded with no indication, and the held entries are not disturbed.
- R8: When the queue is full, an enqueue whose address matches a held entry still coalesces into that entry.
- R9: When a fire removes an entry in the same cycle as an enqueue to that entry's address, the output carries the old contents and the incoming request is stored as a new, separately fireable entry.
- R10: A fire that arrives while the output register is occupied and `outReady` is low is ignored; the named entry stays held and can be fired later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| enqValid | input | 1 | Enqueue strobe |
| enqId | input | ID_W | Identifier of the incoming request |
| enqAddr | input | ADDR_W | Address of the incoming request |
| enqData | input | DATA_W | Data word of the incoming request |
| fireValid | input | 1 | Fire command strobe |
| fireId | input | ID_W | Identifier the fire command names |
| outValid | output | 1 | Output register holds a fired request |
| outId | output | ID_W | Identifier of the fired request |
| outAddr | output | ADDR_W | Address of the fired request |
| outData | output | DATA_W | Data word of the fired request |
| outReady | input | 1 | Downstream accepts the output this cycle |

## Verification
Enqueue and fire can fall in the same cycle, and the hard case is when both target one slot. The bench covers it in one clock by enqueuing to a held address while firing that entry's identifier. It then checks that the output carries the old identifier and data, that a second fire of the old identifier produces nothing, and that a fire of the new identifier returns the new data. A related overlap, a fire that frees a slot while the queue is full, follows the same ordering rule. The full-queue tests check that drops and coalescing leave the other entries intact.

// File: rtl/cqPkg.sv
package cqPkg;

  // Strobes from the control to the datapath for one clock cycle.
  typedef struct packed {
    logic write;   // store enqueue fields at writeIdx
    logic clear;   // invalidate entry at clearIdx
    logic load;    // copy entry at clearIdx into the output register
  } cqStrobe_t;

endpackage

// File: rtl/cqCtrl.sv
module cqCtrl
  import cqPkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     enqValid,
  input  logic                     fireValid,
  input  logic [DEPTH-1:0]         validVec,
  input  logic [DEPTH-1:0]         matchVec,
  input  logic [DEPTH-1:0]         idHitVec,
  input  logic                     outValid,
  input  logic                     outReady,
  output cqStrobe_t                strobe,
  output logic [$clog2(DEPTH)-1:0] writeIdx,
  output logic [$clog2(DEPTH)-1:0] clearIdx
);

  localparam int IDX_W = $clog2(DEPTH);

  logic             outFree;
  logic             fireHit;
  logic [DEPTH-1:0] clearOh;
  logic [DEPTH-1:0] matchEff;
  logic [DEPTH-1:0] freeEff;
  logic [IDX_W-1:0] matchIdx;
  logic [IDX_W-1:0] freeIdx;

  always_comb begin
    outFree = !outValid || outReady;
    fireHit = fireValid && outFree && (|idHitVec);

    clearIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (idHitVec[i]) clearIdx = IDX_W'(i);
    end

    clearOh = '0;
    if (fireHit) clearOh[clearIdx] = 1'b1;

    // Fire is resolved first: the fired slot no longer matches and counts as free.
    matchEff = matchVec & ~clearOh;
    freeEff  = ~validVec | clearOh;

    matchIdx = '0;
    freeIdx  = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (matchEff[i]) matchIdx = IDX_W'(i);
      if (freeEff[i])  freeIdx  = IDX_W'(i);
    end

    strobe.load  = fireHit;
    strobe.clear = fireHit;
    strobe.write = enqValid && ((|matchEff) || (|freeEff));
    writeIdx     = (|matchEff) ? matchIdx : freeIdx;
  end

  assert_fire_miss_R5: assert property (@(posedge clk) disable iff (!rstN)
    (fireValid && !(|idHitVec)) |-> !strobe.load);

  assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (enqValid && (&validVec) && !(|matchVec) && !strobe.clear) |-> !strobe.write);

  assert_full_merge_R8: assert property (@(posedge clk) disable iff (!rstN)
    (enqValid && (|matchVec) && !strobe.clear) |-> strobe.write);

  assert_same_slot_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clear && enqValid && (matchVec == idHitVec) && $onehot(matchVec)) |-> strobe.write);

  assert_busy_fire_R10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !strobe.load);

endmodule

// File: rtl/cqData.sv
module cqData
  import cqPkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int ID_W   = 8,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ID_W-1:0]          enqId,
  input  logic [ADDR_W-1:0]        enqAddr,
  input  logic [DATA_W-1:0]        enqData,
  input  logic [ID_W-1:0]          fireId,
  input  cqStrobe_t                strobe,
  input  logic [$clog2(DEPTH)-1:0] writeIdx,
  input  logic [$clog2(DEPTH)-1:0] clearIdx,
  input  logic                     outReady,
  output logic [DEPTH-1:0]         validVec,
  output logic [DEPTH-1:0]         matchVec,
  output logic [DEPTH-1:0]         idHitVec,
  output logic                     outValid,
  output logic [ID_W-1:0]          outId,
  output logic [ADDR_W-1:0]        outAddr,
  output logic [DATA_W-1:0]        outData
);

  logic [ADDR_W-1:0] addrMem [DEPTH];
  logic [ID_W-1:0]   idMem   [DEPTH];
  logic [DATA_W-1:0] dataMem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : gCompare
    assign matchVec[g] = validVec[g] && (addrMem[g] == enqAddr);
    assign idHitVec[g] = validVec[g] && (idMem[g] == fireId);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validVec <= '0;
    end else begin
      if (strobe.clear) validVec[clearIdx] <= 1'b0;
      if (strobe.write) validVec[writeIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.write) begin
      addrMem[writeIdx] <= enqAddr;
      idMem[writeIdx]   <= enqId;
      dataMem[writeIdx] <= enqData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outId    <= '0;
      outAddr  <= '0;
      outData  <= '0;
    end else if (strobe.load) begin
      outValid <= 1'b1;
      outId    <= idMem[clearIdx];
      outAddr  <= addrMem[clearIdx];
      outData  <= dataMem[clearIdx];
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  assert_single_match_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));

  assert_no_forward_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> !$rose(outValid));

  assert_fire_loads_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> outValid);

  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outId) && $stable(outAddr) && $stable(outData)));

endmodule

// File: rtl/coalesceQueue.sv
module coalesceQueue
  import cqPkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int ID_W   = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enqValid,
  input  logic [ID_W-1:0]   enqId,
  input  logic [ADDR_W-1:0] enqAddr,
  input  logic [DATA_W-1:0] enqData,
  input  logic              fireValid,
  input  logic [ID_W-1:0]   fireId,
  output logic              outValid,
  output logic [ID_W-1:0]   outId,
  output logic [ADDR_W-1:0] outAddr,
  output logic [DATA_W-1:0] outData,
  input  logic              outReady
);

  localparam int IDX_W = $clog2(DEPTH);

  cqStrobe_t        strobe;
  logic [IDX_W-1:0] writeIdx;
  logic [IDX_W-1:0] clearIdx;
  logic [DEPTH-1:0] validVec;
  logic [DEPTH-1:0] matchVec;
  logic [DEPTH-1:0] idHitVec;

  cqCtrl #(.DEPTH(DEPTH)) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enqValid (enqValid),
    .fireValid(fireValid),
    .validVec (validVec),
    .matchVec (matchVec),
    .idHitVec (idHitVec),
    .outValid (outValid),
    .outReady (outReady),
    .strobe   (strobe),
    .writeIdx (writeIdx),
    .clearIdx (clearIdx)
  );

  cqData #(
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W),
    .ID_W  (ID_W),
    .DATA_W(DATA_W)
  ) data (
    .clk     (clk),
    .rstN    (rstN),
    .enqId   (enqId),
    .enqAddr (enqAddr),
    .enqData (enqData),
    .fireId  (fireId),
    .strobe  (strobe),
    .writeIdx(writeIdx),
    .clearIdx(clearIdx),
    .outReady(outReady),
    .validVec(validVec),
    .matchVec(matchVec),
    .idHitVec(idHitVec),
    .outValid(outValid),
    .outId   (outId),
    .outAddr (outAddr),
    .outData (outData)
  );

endmodule

// File: tb/coalesceQueue_test.sv
`timescale 1ns/1ps
module coalesceQueue_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enqValid = 1'b0;
  logic [7:0]  enqId = '0;
  logic [31:0] enqAddr = '0;
  logic [31:0] enqData = '0;
  logic        fireValid = 1'b0;
  logic [7:0]  fireId = '0;
  logic        outValid;
  logic [7:0]  outId;
  logic [31:0] outAddr;
  logic [31:0] outData;
  logic        outReady = 1'b0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  coalesceQueue uut (
    .clk(clk), .rstN(rstN),
    .enqValid(enqValid), .enqId(enqId), .enqAddr(enqAddr), .enqData(enqData),
    .fireValid(fireValid), .fireId(fireId),
    .outValid(outValid), .outId(outId), .outAddr(outAddr), .outData(outData),
    .outReady(outReady)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic expectOut(input logic expV, input logic [7:0] id, input logic [31:0] addr,
                           input logic [31:0] data, input string req);
    check(outValid === expV, {req, " outValid"}, 32'(outValid), 32'(expV));
    if (expV) begin
      check(outId === id, {req, " outId"}, 32'(outId), 32'(id));
      check(outAddr === addr, {req, " outAddr"}, outAddr, addr);
      check(outData === data, {req, " outData"}, outData, data);
    end
  endtask

  task automatic enq(input logic [7:0] id, input logic [31:0] addr, input logic [31:0] data);
    @(negedge clk);
    enqValid = 1'b1; enqId = id; enqAddr = addr; enqData = data;
    @(negedge clk);
    enqValid = 1'b0;
  endtask

  task automatic fire(input logic [7:0] id);
    @(negedge clk);
    fireValid = 1'b1; fireId = id;
    @(negedge clk);
    fireValid = 1'b0;
  endtask

  task automatic drain(input string req);
    @(negedge clk);
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    expectOut(1'b0, 8'h0, 32'h0, 32'h0, req);
  endtask

  task automatic testReset;
    expectOut(1'b0, 8'h0, 32'h0, 32'h0, "R1 after reset");
    fire(8'h00);
    expectOut(1'b0, 8'h0, 32'h0, 32'h0, "R1 fire on empty queue");
  endtask

  task automatic testHoldAndFire;
    enq(8'h01, 32'h1000, 32'hAAAA_0001);
    expectOut(1'b0, 8'h0, 32'h0, 32'h0, "R2 enqueue not forwarded");
    repeat (2) @(negedge clk);
    expectOut(1'b0, 8'h0, 32'h0, 32'h0, "R2 still held");
    fire(8'h01);
    expectOut(1'b1, 8'h01, 32'h1000, 32'hAAAA_0001, "R4 fire hit");
    drain("R6 drain");
    fire(8'h01);
    expectOut(1'b0, 8'h0, 32'h0, 32'h0, "R4 entry removed");
  endtask

  task automatic testCoalesce;
    enq(8'h02, 32'h2000, 32'hBBBB_0002);
    enq(8'h03, 32'h2000, 32'hBBBB_0003);
    fire(8'h02);
    expectOut(1'b0, 8'h0, 32'h0, 32'h0, "R3 replaced id gone");
    fire(8'h03);
    expectOut(1'b1, 8'h03, 32'h2000, 32'hBBBB_0003, "R3 merged contents");
    drain("R3 drain");
    fire(8'h03);
    expectOut(1'b0, 8'h0, 32'h0, 32'h0, "R3 single slot used");
  endtask

  task automatic testMiss;
    enq(8'h04, 32'h3000, 32'hCCCC_0004);
    fire(8'h09);
    expectOut(1'b0, 8'h0, 32'h0, 32'h0, "R5 fire miss ignored");
    fire(8'h04);
    expectOut(1'b1, 8'h04, 32'h3000, 32'hCCCC_0004, "R5 entry intact");
    drain("R5 drain");
  endtask

  task automatic testBusyOutput;
    enq(8'h05, 32'h4000, 32'hDDDD_0005);
    enq(8'h06, 32'h4004, 32'hDDDD_0006);
    fire(8'h05);
    expectOut(1'b1, 8'h05, 32'h4000, 32'hDDDD_0005, "R4 first fire");
    repeat (3) @(negedge clk);
    expectOut(1'b1, 8'h05, 32'h4000, 32'hDDDD_0005, "R6 held while not ready");
    fire(8'h06);
    expectOut(1'b1, 8'h05, 32'h4000, 32'hDDDD_0005, "R10 busy fire ignored");
    drain("R6 released on ready");
    fire(8'h06);
    expectOut(1'b1, 8'h06, 32'h4004, 32'hDDDD_0006, "R10 entry kept");
    drain("R10 drain");
  endtask

  task automatic testFull;
    for (int i = 0; i < 8; i++) enq(8'(8'h10 + i), 32'h5000 + 32'(i), 32'hEE00_0000 + 32'(i));
    enq(8'h20, 32'h5100, 32'hEEEE_0020);
    expectOut(1'b0, 8'h0, 32'h0, 32'h0, "R7 drop is silent");
    enq(8'h21, 32'h5003, 32'hEEEE_0021);
    fire(8'h20);
    expectOut(1'b0, 8'h0, 32'h0, 32'h0, "R7 dropped request absent");
    fire(8'h13);
    expectOut(1'b0, 8'h0, 32'h0, 32'h0, "R8 old id replaced");
    fire(8'h21);
    expectOut(1'b1, 8'h21, 32'h5003, 32'hEEEE_0021, "R8 merge when full");
    drain("R8 drain");
    for (int i = 0; i < 8; i++) begin
      if (i != 3) begin
        fire(8'(8'h10 + i));
        expectOut(1'b1, 8'(8'h10 + i), 32'h5000 + 32'(i), 32'hEE00_0000 + 32'(i), "R7 entries undisturbed");
        drain("R7 drain");
      end
    end
  endtask

  task automatic testSameCycle;
    enq(8'h30, 32'h6000, 32'hF0F0_0030);
    @(negedge clk);
    fireValid = 1'b1; fireId = 8'h30;
    enqValid = 1'b1; enqId = 8'h31; enqAddr = 32'h6000; enqData = 32'hF0F0_0031;
    @(negedge clk);
    fireValid = 1'b0; enqValid = 1'b0;
    expectOut(1'b1, 8'h30, 32'h6000, 32'hF0F0_0030, "R9 old contents out");
    drain("R9 drain");
    fire(8'h30);
    expectOut(1'b0, 8'h0, 32'h0, 32'h0, "R9 old id removed");
    fire(8'h31);
    expectOut(1'b1, 8'h31, 32'h6000, 32'hF0F0_0031, "R9 fresh entry");
    drain("R9 final drain");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testHoldAndFire();
    testCoalesce();
    testMiss();
    testBusyOutput();
    testFull();
    testSameCycle();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule